// File: doc/BRIEF.md
# Software-Filled Set-Associative Translation Buffer

This block caches page translations that a software refill handler writes into it. Storage is split into two halves: one serves instruction fetches, the other serves loads and stores. Each half is organised as `WAYS` ways of `SETS` entries. The low bits of the effective page number pick the set. Each entry holds the effective page number it was loaded for and two page-table words. The first word carries a valid flag, a hash-select flag and a comparison tag. The second word carries the real page number, the cache attribute bits, two protection bits, and the referenced and changed flags.

A lookup presents an effective page number, an access type, a protection key, a no-execute flag and a compare tag. A small state machine accepts the request in `IDLE` and moves to `PROBE`. In `PROBE` it examines one way per cycle. It then spends one cycle in `FINISH`, which presents the result and writes the updated flags back into the selected entry. There are three transitions out of the resting states. `IDLE -> PROBE` happens when a request is accepted. `PROBE -> FINISH` happens when a way grants access or when the last way has been examined. `FINISH -> IDLE` is taken unconditionally. `PROBE` stays in `PROBE` for each remaining way. The result gives a code, the real page number, read/write/execute rights and the updated second page-table word. On a miss, the refill handler walks the page table and calls the load port. A single-cycle invalidate input clears the valid flag of every entry.

Top module: `swtlb_lookup`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, `resp_valid` is 0, and any lookup returns the miss code.
- R2: A request with `req_acc` = 2 (fetch) searches only the instruction half. `req_acc` = 0 (load) and 1 (store) search only the data half. The set is `req_vpage` modulo `SETS`.
- R3: An entry matches only if all of the following hold: its stored page number equals `req_vpage`; bit 31 (valid) of its first word is 1; bit 6 (hash-select) of its first word is 0; and the first word equals `req_tag` under mask 0x7FFFFFBF.
- R4: Once a match has been selected, a later match whose second word differs from it under mask 0xFFFFF07B is ignored. The mask covers page number bits 31:12, attribute bits 6:3 and protection bits 1:0.
- R5: Ways are searched in ascending order, one per cycle. The first match that grants access ends the search, and `resp_valid` rises k+1 cycles after acceptance for a grant in way k. A match that is denied is remembered and the search continues. Without a grant, the response comes `WAYS` cycles after acceptance. `req_ready` is 0 while a lookup is in progress.
- R6: Rights `resp_prot` use bit 0 for read, bit 1 for write and bit 2 for execute. They are derived from the protection bits pp (bits 1:0 of the second word) and the key:
  - Key 0: pp 0 to 2 give read and write; pp 3 gives read only.
  - Key 1: pp 0 gives nothing; pp 1 and pp 3 give read only; pp 2 gives read and write.
  - Execute equals read, and is cleared when `req_nx` is 1.
  - A load needs read, a store needs write and a fetch needs execute.
- R7: `resp_code` is 0 for granted, 1 for no match and 2 for a denied match. On no match, `resp_prot`, `resp_rpn` and `resp_pte` are 0.
- R8: On any selected match, the referenced flag (bit 8 of the second word) is set. It is set in both the stored entry and `resp_pte`.
- R9: A granted store sets the changed flag (bit 7) in the entry and in `resp_pte`. For any other access whose entry has the changed flag clear, the write right is removed from `resp_prot`.
- R10: A cycle with `inv_all` high clears the valid flag of every entry. Later lookups miss until the entries are loaded again.
- R11: A cycle with `ld_en` high writes `ld_epn`, `ld_pte0` and `ld_pte1` into entry set + way*`SETS` + (`ld_code` ? `WAYS`*`SETS` : 0). The set is `ld_epn` modulo `SETS`. Within that entry a load overrides an invalidate or flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Controller is idle |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch |
| req_vpage | input | 32-PAGE_BITS | Effective page number |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | No-execute flag |
| req_tag | input | 32 | Compare tag |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_code | output | 2 | 0 granted, 1 no match, 2 denied |
| resp_rpn | output | 32-PAGE_BITS | Real page number |
| resp_prot | output | 3 | Rights {exec, write, read} |
| resp_pte | output | 32 | Updated second word of the selected entry |
| ld_en | input | 1 | Write one entry |
| ld_code | input | 1 | 1 selects the instruction half |
| ld_way | input | WAY_W | Way to write |
| ld_epn | input | 32-PAGE_BITS | Effective page number of the entry |
| ld_pte0 | input | 32 | First word (valid, hash-select, tag) |
| ld_pte1 | input | 32 | Second word (page, attributes, flags, pp) |
| inv_all | input | 1 | Clear every valid flag |

## Verification
The bench covers the following corner cases:
- **Halves.** A fetch and a load hit the same set number in different halves. A design that shared one half between them would return a hit where a miss is expected.
- **Disagreeing ways.** A set holds a denied match in way 0 and a disagreeing, grantable match in way 1. A design that skipped the consistency check would report a grant with the wrong page.
- **Changed flag.** A load to a clean page is followed by a store and then another load. A design that mishandled the changed flag would return write rights on the first load, or withhold them after the store.
- **Timing and rejects.** Latency is measured for grants in way 0 and way 1 and for misses, which catches a design that kept searching after a grant. Entries with the hash-select flag set, with no valid flag, or with the wrong tag or page must all miss, and so must every entry after an invalidate.

// File: rtl/swtlb_pkg.sv
`timescale 1ns/1ps
package swtlb_pkg;
    localparam int PTE_W = 32;

    localparam logic [PTE_W-1:0] VALID_MASK = 32'h8000_0000;
    localparam logic [PTE_W-1:0] HSEL_MASK  = 32'h0000_0040;
    localparam logic [PTE_W-1:0] TAG_MASK   = 32'h7FFF_FFBF;
    localparam logic [PTE_W-1:0] AGREE_MASK = 32'hFFFF_F07B;
    localparam logic [PTE_W-1:0] REF_MASK   = 32'h0000_0100;
    localparam logic [PTE_W-1:0] CHG_MASK   = 32'h0000_0080;

    localparam int PROT_R = 0;
    localparam int PROT_W = 1;
    localparam int PROT_X = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RC_GRANT = 2'd0,
        RC_MISS  = 2'd1,
        RC_DENY  = 2'd2
    } rc_e;

    function automatic logic permits(input logic [2:0] prot, input acc_e acc);
        logic ok;
        case (acc)
            ACC_LOAD:  ok = prot[PROT_R];
            ACC_STORE: ok = prot[PROT_W];
            ACC_FETCH: ok = prot[PROT_X];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/swtlb_prot.sv
`timescale 1ns/1ps
module swtlb_prot
    import swtlb_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       nx,
    output logic [2:0] prot
);
    always_comb begin
        prot = 3'b000;
        if (key) begin
            prot[PROT_R] = (pp != 2'd0);
            prot[PROT_W] = (pp == 2'd2);
        end else begin
            prot[PROT_R] = 1'b1;
            prot[PROT_W] = (pp != 2'd3);
        end
        prot[PROT_X] = prot[PROT_R] & ~nx;
    end
endmodule

// File: rtl/swtlb_array.sv
`timescale 1ns/1ps
module swtlb_array
    import swtlb_pkg::*;
#(
    parameter int NENT  = 32,
    parameter int EPN_W = 20,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [EPN_W-1:0] ld_epn,
    input  logic [PTE_W-1:0] ld_pte0,
    input  logic [PTE_W-1:0] ld_pte1,
    input  logic             inv_all,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_chg,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [EPN_W-1:0] rd_epn,
    output logic [PTE_W-1:0] rd_pte0,
    output logic [PTE_W-1:0] rd_pte1
);
    logic [EPN_W-1:0] epn_q [NENT];
    logic [PTE_W-1:0] p0_q  [NENT];
    logic [PTE_W-1:0] p1_q  [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                epn_q[e] <= '0;
                p0_q[e]  <= '0;
                p1_q[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < NENT; e++) begin
                if (ld_en && ld_idx == IDX_W'(e)) begin
                    epn_q[e] <= ld_epn;
                    p0_q[e]  <= ld_pte0;
                    p1_q[e]  <= ld_pte1;
                end else begin
                    if (inv_all)
                        p0_q[e] <= p0_q[e] & ~VALID_MASK;
                    if (upd_en && upd_idx == IDX_W'(e))
                        p1_q[e] <= p1_q[e] | REF_MASK | (upd_chg ? CHG_MASK : '0);
                end
            end
        end
    end

    assign rd_epn  = epn_q[rd_idx];
    assign rd_pte0 = p0_q[rd_idx];
    assign rd_pte1 = p1_q[rd_idx];

    // R10: an invalidate without a competing load leaves entry 0 invalid
    p_inv_drops_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !ld_en) |=> ((p0_q[0] & VALID_MASK) == '0));

    // R8: a flag update leaves the referenced flag set in the entry
    p_upd_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en) |=> ((p1_q[$past(upd_idx)] & REF_MASK) != '0));
endmodule

// File: rtl/swtlb_ctrl.sv
`timescale 1ns/1ps
module swtlb_ctrl
    import swtlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SETS      = 8,
    parameter int PAGE_BITS = 12,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int EPN_W = PTE_W - PAGE_BITS,
    localparam int NENT  = 2 * WAYS * SETS,
    localparam int IDX_W = $clog2(NENT),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_acc,
    input  logic [EPN_W-1:0] req_vpage,
    input  logic             req_key,
    input  logic             req_nx,
    input  logic [PTE_W-1:0] req_tag,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [EPN_W-1:0] resp_rpn,
    output logic [2:0]       resp_prot,
    output logic [PTE_W-1:0] resp_pte,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [EPN_W-1:0] rd_epn,
    input  logic [PTE_W-1:0] rd_pte0,
    input  logic [PTE_W-1:0] rd_pte1,
    output logic             q_key,
    output logic             q_nx,
    input  logic [2:0]       prot_in,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic             upd_chg
);
    typedef enum logic [1:0] {S_IDLE, S_PROBE, S_FINISH} state_e;

    state_e state_q, state_d;
    logic [WAY_W-1:0] way_q;
    logic [EPN_W-1:0] page_q;
    acc_e             acc_q;
    logic             key_q, nx_q, have_q;
    logic [PTE_W-1:0] tag_q, sel_pte_q;
    logic [2:0]       sel_prot_q;
    logic [IDX_W-1:0] sel_idx_q;
    rc_e              code_q;

    logic hit, clash, take, grant, last_way, store_ok, chg_now;
    logic [PTE_W-1:0] pte_out;

    assign q_key = key_q;
    assign q_nx  = nx_q;

    always_comb begin
        rd_idx = IDX_W'(page_q[SET_W-1:0])
               + IDX_W'(way_q) * IDX_W'(SETS)
               + ((acc_q == ACC_FETCH) ? IDX_W'(WAYS * SETS) : '0);
        hit = ((rd_pte0 & VALID_MASK) != '0)
            && ((rd_pte0 & HSEL_MASK) == '0)
            && (rd_epn == page_q)
            && (((rd_pte0 ^ tag_q) & TAG_MASK) == '0);
        clash    = have_q && (((rd_pte1 ^ sel_pte_q) & AGREE_MASK) != '0);
        take     = hit && !clash;
        grant    = take && permits(prot_in, acc_q);
        last_way = (way_q == WAY_W'(WAYS - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_PROBE;
            S_PROBE:  if (grant || last_way) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // search context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q      <= '0;
            page_q     <= '0;
            acc_q      <= ACC_LOAD;
            key_q      <= 1'b0;
            nx_q       <= 1'b0;
            tag_q      <= '0;
            have_q     <= 1'b0;
            sel_pte_q  <= '0;
            sel_prot_q <= '0;
            sel_idx_q  <= '0;
            code_q     <= RC_MISS;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    way_q      <= '0;
                    page_q     <= req_vpage;
                    acc_q      <= acc_e'(req_acc);
                    key_q      <= req_key;
                    nx_q       <= req_nx;
                    tag_q      <= req_tag;
                    have_q     <= 1'b0;
                    sel_pte_q  <= '0;
                    sel_prot_q <= '0;
                    sel_idx_q  <= '0;
                    code_q     <= RC_MISS;
                end
                S_PROBE: begin
                    if (take) begin
                        sel_pte_q  <= rd_pte1;
                        sel_prot_q <= prot_in;
                        sel_idx_q  <= rd_idx;
                        have_q     <= 1'b1;
                        code_q     <= grant ? RC_GRANT : RC_DENY;
                    end
                    if (!(grant || last_way)) way_q <= way_q + 1'b1;
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        store_ok = (acc_q == ACC_STORE) && (code_q == RC_GRANT);
        chg_now  = ((sel_pte_q & CHG_MASK) != '0) || store_ok;
        pte_out  = sel_pte_q | REF_MASK | (store_ok ? CHG_MASK : '0);
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_code  = RC_MISS;
        resp_pte   = '0;
        resp_prot  = '0;
        upd_en     = 1'b0;
        upd_idx    = sel_idx_q;
        upd_chg    = store_ok;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_PROBE: ;
            S_FINISH: begin
                resp_valid = 1'b1;
                resp_code  = code_q;
                if (have_q) begin
                    upd_en   = 1'b1;
                    resp_pte = pte_out;
                    resp_prot = sel_prot_q;
                    if (!chg_now) resp_prot[PROT_W] = 1'b0;
                end
            end
            default: ;
        endcase
        resp_rpn = resp_pte[PTE_W-1:PAGE_BITS];
    end

    // R5: a response is followed by the idle state
    p_finish_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    // R5: a grant carries the right the access needed
    p_grant_allows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RC_GRANT) |-> permits(resp_prot, acc_q));

    // R6: the rights evaluator never gives write without read
    p_write_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE) |-> !(prot_in[PROT_W] && !prot_in[PROT_R]));

    // R7: a miss reports nothing
    p_miss_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RC_MISS) |-> (resp_prot == 3'b000 && resp_pte == '0));

    // R8: every selected match reports the referenced flag
    p_ref_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code != RC_MISS) |-> ((resp_pte & REF_MASK) != '0));

    // R9: a granted store leaves the changed flag and write right
    p_store_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && store_ok) |-> (((resp_pte & CHG_MASK) != '0) && resp_prot[PROT_W]));
endmodule

// File: rtl/swtlb_lookup.sv
`timescale 1ns/1ps
module swtlb_lookup
    import swtlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SETS      = 8,
    parameter int PAGE_BITS = 12,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int EPN_W = PTE_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_acc,
    input  logic [EPN_W-1:0] req_vpage,
    input  logic             req_key,
    input  logic             req_nx,
    input  logic [31:0]      req_tag,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [EPN_W-1:0] resp_rpn,
    output logic [2:0]       resp_prot,
    output logic [31:0]      resp_pte,
    input  logic             ld_en,
    input  logic             ld_code,
    input  logic [WAY_W-1:0] ld_way,
    input  logic [EPN_W-1:0] ld_epn,
    input  logic [31:0]      ld_pte0,
    input  logic [31:0]      ld_pte1,
    input  logic             inv_all
);
    localparam int NENT  = 2 * WAYS * SETS;
    localparam int IDX_W = $clog2(NENT);
    localparam int SET_W = $clog2(SETS);

    logic [IDX_W-1:0] ld_idx, rd_idx, upd_idx;
    logic [EPN_W-1:0] rd_epn;
    logic [PTE_W-1:0] rd_pte0, rd_pte1;
    logic             q_key, q_nx, upd_en, upd_chg;
    logic [2:0]       prot_w;

    assign ld_idx = IDX_W'(ld_epn[SET_W-1:0])
                  + IDX_W'(ld_way) * IDX_W'(SETS)
                  + (ld_code ? IDX_W'(WAYS * SETS) : '0);

    swtlb_array #(.NENT(NENT), .EPN_W(EPN_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_epn(ld_epn),
        .ld_pte0(ld_pte0), .ld_pte1(ld_pte1), .inv_all(inv_all),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_chg(upd_chg),
        .rd_idx(rd_idx), .rd_epn(rd_epn), .rd_pte0(rd_pte0), .rd_pte1(rd_pte1)
    );

    swtlb_prot u_prot (
        .key(q_key), .pp(rd_pte1[1:0]), .nx(q_nx), .prot(prot_w)
    );

    swtlb_ctrl #(.WAYS(WAYS), .SETS(SETS), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_acc(req_acc),
        .req_vpage(req_vpage), .req_key(req_key), .req_nx(req_nx), .req_tag(req_tag),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_rpn(resp_rpn),
        .resp_prot(resp_prot), .resp_pte(resp_pte),
        .rd_idx(rd_idx), .rd_epn(rd_epn), .rd_pte0(rd_pte0), .rd_pte1(rd_pte1),
        .q_key(q_key), .q_nx(q_nx), .prot_in(prot_w),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_chg(upd_chg)
    );
endmodule

// File: tb/swtlb_lookup_tb.sv
`timescale 1ns/1ps
module swtlb_lookup_tb;
    localparam logic [31:0] VB = 32'h8000_0000;
    localparam logic [31:0] TA = 32'h0012_3485;
    localparam logic [31:0] TB = 32'h0012_3585;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
    localparam logic [1:0] GR = 2'd0, MS = 2'd1, DN = 2'd2;

    typedef struct packed {
        logic [1:0]  acc;
        logic [19:0] vpage;
        logic        key;
        logic        nx;
        logic [31:0] tag;
        logic [1:0]  code;
        logic [2:0]  prot;
        logic [31:0] pte;
        logic [3:0]  lat;
        logic [3:0]  req;
    } vec_t;

    // req field names the requirement whose rights/match rule the vector targets
    localparam vec_t VECS [19] = '{
        '{LD, 20'h00003, 1'b0, 1'b0, TA, GR, 3'b101, 32'hAAAAA102, 4'd1, 4'd6},  // R6 clean page loses write
        '{ST, 20'h00003, 1'b0, 1'b0, TA, GR, 3'b111, 32'hAAAAA182, 4'd1, 4'd9},  // R9 store marks changed
        '{LD, 20'h00003, 1'b0, 1'b0, TA, GR, 3'b111, 32'hAAAAA182, 4'd1, 4'd9},  // R9 dirty keeps write
        '{FE, 20'h00003, 1'b0, 1'b0, TA, MS, 3'b000, 32'h00000000, 4'd2, 4'd2},  // R2 code half empty
        '{LD, 20'h00003, 1'b1, 1'b1, TA, GR, 3'b011, 32'hAAAAA182, 4'd1, 4'd6},  // R6 key1 pp2 nx
        '{LD, 20'h00003, 1'b0, 1'b0, TB, MS, 3'b000, 32'h00000000, 4'd2, 4'd3},  // R3 tag differs
        '{LD, 20'h00013, 1'b0, 1'b0, TA, MS, 3'b000, 32'h00000000, 4'd2, 4'd3},  // R3 page differs
        '{ST, 20'h00005, 1'b0, 1'b0, TA, DN, 3'b101, 32'hBBBBB103, 4'd2, 4'd7},  // R7 denied store
        '{LD, 20'h00005, 1'b1, 1'b0, TA, GR, 3'b101, 32'hBBBBB103, 4'd1, 4'd6},  // R6 key1 pp3
        '{LD, 20'h00006, 1'b1, 1'b0, TA, DN, 3'b000, 32'hCCCCC100, 4'd2, 4'd6},  // R6 key1 pp0
        '{LD, 20'h00006, 1'b0, 1'b1, TA, GR, 3'b001, 32'hCCCCC100, 4'd1, 4'd6},  // R6 key0 pp0 nx
        '{FE, 20'h00002, 1'b0, 1'b0, TA, GR, 3'b101, 32'hDDDDD101, 4'd2, 4'd2},  // R2 code way1
        '{FE, 20'h00002, 1'b0, 1'b1, TA, DN, 3'b001, 32'hDDDDD101, 4'd2, 4'd6},  // R6 nx blocks fetch
        '{LD, 20'h00002, 1'b0, 1'b0, TA, MS, 3'b000, 32'h00000000, 4'd2, 4'd2},  // R2 data half empty
        '{LD, 20'h00007, 1'b0, 1'b0, TA, MS, 3'b000, 32'h00000000, 4'd2, 4'd3},  // R3 hsel / invalid
        '{LD, 20'h00004, 1'b1, 1'b0, TA, DN, 3'b000, 32'hEEEEE100, 4'd2, 4'd4},  // R4 clash ignored
        '{LD, 20'h00004, 1'b0, 1'b0, TA, GR, 3'b101, 32'hEEEEE100, 4'd1, 4'd4},  // R4 way0 grants
        '{LD, 20'h00001, 1'b0, 1'b0, TA, GR, 3'b101, 32'h12345102, 4'd1, 4'd5},  // R5 first grant stops
        '{ST, 20'h00001, 1'b0, 1'b0, TA, GR, 3'b111, 32'h12345182, 4'd1, 4'd5}   // R5 store way0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_acc = 2'd0;
    logic [19:0] req_vpage = '0;
    logic        req_key = 1'b0, req_nx = 1'b0;
    logic [31:0] req_tag = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [19:0] resp_rpn;
    logic [2:0]  resp_prot;
    logic [31:0] resp_pte;
    logic        ld_en = 1'b0, ld_code = 1'b0;
    logic [0:0]  ld_way = '0;
    logic [19:0] ld_epn = '0;
    logic [31:0] ld_pte0 = '0, ld_pte1 = '0;
    logic        inv_all = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    swtlb_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_acc(req_acc), .req_vpage(req_vpage), .req_key(req_key), .req_nx(req_nx),
        .req_tag(req_tag), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_rpn(resp_rpn), .resp_prot(resp_prot), .resp_pte(resp_pte),
        .ld_en(ld_en), .ld_code(ld_code), .ld_way(ld_way), .ld_epn(ld_epn),
        .ld_pte0(ld_pte0), .ld_pte1(ld_pte1), .inv_all(inv_all)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic load(input logic code, input logic way, input logic [19:0] epn,
                        input logic [31:0] p0, input logic [31:0] p1);
        @(negedge clk);
        ld_en = 1'b1; ld_code = code; ld_way = way; ld_epn = epn; ld_pte0 = p0; ld_pte1 = p1;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic lookup(input vec_t v);
        int  lat;
        logic got;
        logic [1:0] c; logic [2:0] p; logic [31:0] t; logic [19:0] r;
        @(negedge clk);
        req_valid = 1'b1; req_acc = v.acc; req_vpage = v.vpage;
        req_key = v.key; req_nx = v.nx; req_tag = v.tag;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R5 busy ready", {31'd0, req_ready}, 32'd0);
        lat = 0; got = 1'b0;
        while (!got && lat < 8) begin
            @(negedge clk);
            lat++;
            if (resp_valid) begin
                got = 1'b1; c = resp_code; p = resp_prot; t = resp_pte; r = resp_rpn;
            end
        end
        chk("R5 latency", 32'(lat), 32'(v.lat));
        if (got) begin
            chk("R7 code", {30'd0, c}, {30'd0, v.code});
            chk($sformatf("R%0d prot", v.req), {29'd0, p}, {29'd0, v.prot});
            chk("R8 pte", t, v.pte);
            chk("R7 rpn", {12'd0, r}, {12'd0, v.pte[31:12]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'd0, resp_valid}, 32'd0);
        lookup('{LD, 20'h00003, 1'b0, 1'b0, TA, MS, 3'b000, 32'h0, 4'd2, 4'd1}); // R1

        // R11 entries through the load port
        load(1'b0, 1'b0, 20'h00003, VB | TA, 32'hAAAAA002);
        load(1'b0, 1'b0, 20'h00005, VB | TA, 32'hBBBBB003);
        load(1'b0, 1'b0, 20'h00006, VB | TA, 32'hCCCCC000);
        load(1'b1, 1'b1, 20'h00002, VB | TA, 32'hDDDDD001);
        load(1'b0, 1'b0, 20'h00007, VB | TA | 32'h40, 32'h77777002);
        load(1'b0, 1'b1, 20'h00007, TA, 32'h77777002);
        load(1'b0, 1'b0, 20'h00004, VB | TA, 32'hEEEEE000);
        load(1'b0, 1'b1, 20'h00004, VB | TA, 32'hFFFFF002);
        load(1'b0, 1'b0, 20'h00001, VB | TA, 32'h12345002);
        load(1'b0, 1'b1, 20'h00001, VB | TA, 32'h12345002);

        for (int i = 0; i < 19; i++) lookup(VECS[i]);

        // R10: invalidate all, then the loaded page misses
        @(negedge clk); inv_all = 1'b1;
        @(posedge clk); #1 inv_all = 1'b0;
        lookup('{LD, 20'h00003, 1'b0, 1'b0, TA, MS, 3'b000, 32'h0, 4'd2, 4'd10});
        lookup('{FE, 20'h00002, 1'b0, 1'b0, TA, MS, 3'b000, 32'h0, 4'd2, 4'd10});

        // R11: reload into way 1 after invalidate, found on the second probe
        load(1'b0, 1'b1, 20'h00003, VB | TA, 32'hAAAAA002);
        lookup('{LD, 20'h00003, 1'b0, 1'b0, TA, GR, 3'b101, 32'hAAAAA102, 4'd2, 4'd11});

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule